// File: doc/BRIEF.md
# Augmented Input Decoder with Built-In Pattern Source

This block sits in front of the product-term array of a programmable logic array and drives its bit lines. In ordinary operation it registers each input bit and presents it as a pair of lines: one carrying the bit, the other carrying its inverse. Two mode controls repurpose the same decoder. One mode turns it into a pattern source for testing the product-term array. The other forces every line low while the rest of the array is exercised.

The pattern source has one shift stage per input bit. A toggle flop steers each stage onto either line of its pair, and the line that is not selected is held at 0. After entering the pattern mode, the lines show two all-zero patterns. A single 1 then walks across the lines one position per cycle, and the sequence then repeats. A check output reports the NOR of all bit lines, so a response monitor can tell the zero patterns from the walking ones. The combination of both controls high has no function: it drives the lines low and raises a flag.

Top module: `ad_input_decoder`

## Requirements
- R1: With `t1_i=0` and `t2_i=0`, the clock edge that samples them sets `bl_o[2k]` to `din_i[k]` and `bl_o[2k+1]` to the inverse of `din_i[k]`, for every input `k`.
- R2: With `t2_i=1` and `t1_i=0`, every bit of `bl_o` is 0 after the edge. If `t1_i=1, t2_i=0` follows, the pattern sequence starts again from its first pattern.
- R3: On the first two edges that sample `t1_i=1, t2_i=0` after any other mode, `bl_o` is all zero.
- R4: On the following edges in that mode, `bl_o` is one-hot. The 1 steps from bit 0 to bit 2*N_IN-1, moving up by one bit position on each edge.
- R5: After the pattern with bit 2*N_IN-1 set, the sequence restarts with two all-zero patterns, so its period is 2*N_IN+2 cycles.
- R6: `e1_o` is 1 exactly when every bit of `bl_o` is 0. It is therefore 0 in decode mode and 1 after reset.
- R7: With `t1_i=1` and `t2_i=1`, `bl_o` is all zero and `illegal_o` is 1 after the edge. In every other mode `illegal_o` is 0 after the edge.
- R8: When the block leaves the pattern mode for decode mode, the next edge gives normal decoding. Re-entering the pattern mode starts again from the two zero patterns.
- R9: In the pattern mode, `din_i` has no effect on `bl_o`.
- R10: An active-low asynchronous reset clears `bl_o` and `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| t1_i | input | 1 | Selects the pattern mode for the product-term array |
| t2_i | input | 1 | Forces all lines low and clears the pattern source |
| din_i | input | N_IN | Input bits to decode |
| bl_o | output | 2*N_IN | Bit lines: even index is the true line, odd index is the complement line |
| e1_o | output | 1 | NOR of all bit lines |
| illegal_o | output | 1 | Set after an edge that sampled both controls high |

## Verification
Two things can land on the same edge: the pattern source being cleared and a fresh pattern being requested. The bench provokes this by pulsing the forcing control for one cycle in the middle of a walking sequence, and by dropping to decode mode for one cycle, before asserting the pattern mode again. The result is judged correct only if the next edge gives zero lines or a correct decode, and the next three edges give zero, zero, and a 1 in bit 0. A stale walking position must not show up.

// File: rtl/ad_pkg.sv
package ad_pkg;
   // encoding is {t2, t1}
   typedef enum logic [1:0] {
      MODE_RUN   = 2'b00,
      MODE_PTEST = 2'b01,
      MODE_FORCE = 2'b10,
      MODE_BAD   = 2'b11
   } ad_mode_e;

   function automatic ad_mode_e mode_of(input logic t1, input logic t2);
      return ad_mode_e'({t2, t1});
   endfunction
endpackage

// File: rtl/ad_mode_decode.sv
module ad_mode_decode
   import ad_pkg::*;
(
   input  logic     t1_i,
   input  logic     t2_i,
   output ad_mode_e mode_o,
   output logic     gen_run_o,
   output logic     bad_o
);
   always_comb begin
      mode_o    = mode_of(t1_i, t2_i);
      gen_run_o = (mode_o == MODE_PTEST);
      bad_o     = (mode_o == MODE_BAD);
   end
endmodule

// File: rtl/ad_walk_gen.sv
module ad_walk_gen #(
   parameter int N_STG = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   output logic [2*N_STG-1:0] pat_o
);
   localparam int          LEAD_W    = 2;
   localparam logic [LEAD_W-1:0] LEAD_DONE = 2'd2;
   localparam logic [N_STG-1:0]  SEED      = N_STG'(1);

   logic [LEAD_W-1:0] lead_q;
   logic [N_STG-1:0]  stg_q;
   logic              sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_q <= '0;
         stg_q  <= '0;
         sel_q  <= 1'b0;
      end else if (!run_i) begin
         lead_q <= '0;
         stg_q  <= '0;
         sel_q  <= 1'b0;
      end else if (lead_q != LEAD_DONE) begin
         lead_q <= LEAD_W'(lead_q + 1'b1);
         sel_q  <= 1'b0;
         if (lead_q == LEAD_DONE - 1'b1)
            stg_q <= SEED;
      end else if (!sel_q) begin
         sel_q <= 1'b1;
      end else begin
         sel_q <= 1'b0;
         if (stg_q[N_STG-1]) begin
            lead_q <= '0;
            stg_q  <= '0;
         end else begin
            stg_q <= stg_q << 1;
         end
      end
   end

   for (genvar k = 0; k < N_STG; k++) begin : g_steer
      assign pat_o[2*k]   = stg_q[k] & ~sel_q;
      assign pat_o[2*k+1] = stg_q[k] &  sel_q;
   end
endmodule

// File: rtl/ad_line_drive.sv
module ad_line_drive
   import ad_pkg::*;
#(
   parameter int N_IN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ad_mode_e          mode_i,
   input  logic [N_IN-1:0]   din_i,
   input  logic [2*N_IN-1:0] pat_i,
   output logic [2*N_IN-1:0] bl_o
);
   for (genvar k = 0; k < N_IN; k++) begin : g_pair
      logic [1:0] pair_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pair_q <= 2'b00;
         else begin
            case (mode_i)
               MODE_RUN:   pair_q <= {~din_i[k], din_i[k]};
               MODE_PTEST: pair_q <= pat_i[2*k+1 -: 2];
               default:    pair_q <= 2'b00;
            endcase
         end
      end
      assign bl_o[2*k+1 -: 2] = pair_q;
   end
endmodule

// File: rtl/ad_input_decoder.sv
module ad_input_decoder
   import ad_pkg::*;
#(
   parameter int N_IN = 4,
   localparam int N_BL = 2 * N_IN
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            t1_i,
   input  logic            t2_i,
   input  logic [N_IN-1:0] din_i,
   output logic [N_BL-1:0] bl_o,
   output logic            e1_o,
   output logic            illegal_o
);
   if (N_IN < 1) begin : g_bad_width
      $error("ad_input_decoder: N_IN must be at least 1");
   end

   ad_mode_e        mode;
   logic            gen_run;
   logic            bad;
   logic [N_BL-1:0] pat;
   logic            illegal_q;

   ad_mode_decode u_mode (
      .t1_i      (t1_i),
      .t2_i      (t2_i),
      .mode_o    (mode),
      .gen_run_o (gen_run),
      .bad_o     (bad)
   );

   ad_walk_gen #(.N_STG(N_IN)) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (gen_run),
      .pat_o (pat)
   );

   ad_line_drive #(.N_IN(N_IN)) u_drive (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode),
      .din_i  (din_i),
      .pat_i  (pat),
      .bl_o   (bl_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) illegal_q <= 1'b0;
      else        illegal_q <= bad;
   end

   assign illegal_o = illegal_q;
   assign e1_o      = ~|bl_o;
endmodule

// File: rtl/ad_input_decoder_chk.sv
module ad_input_decoder_chk #(
   parameter int N_IN = 4,
   localparam int N_BL = 2 * N_IN
) (
   input logic            clk,
   input logic            rst_n,
   input logic            t1_i,
   input logic            t2_i,
   input logic [N_BL-1:0] bl_o,
   input logic            e1_o,
   input logic            illegal_o
);
   logic prev_ptest;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_ptest <= 1'b0;
      else        prev_ptest <= t1_i & ~t2_i;
   end

   // R1, R6: decode mode gives exactly one high line per pair, so the check output is low
   a_r1_pair_weight: assert property (@(posedge clk) disable iff (!rst_n)
      (!t1_i && !t2_i) |=> ($countones(bl_o) == N_IN && !e1_o));

   // R2: the forcing control clears every line
   a_r2_force_low: assert property (@(posedge clk) disable iff (!rst_n)
      (t2_i && !t1_i) |=> (bl_o == '0 && !illegal_o));

   // R4: at most one line is high in the pattern mode
   a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_i && !t2_i) |=> $onehot0(bl_o));

   // R4: the walking 1 moves up by one position
   a_r4_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_i && !t2_i && prev_ptest && bl_o != '0 && !bl_o[N_BL-1])
      |=> (bl_o == ($past(bl_o) << 1)));

   // R5: the last walking pattern is followed by a zero pattern
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_i && !t2_i && prev_ptest && bl_o[N_BL-1]) |=> (bl_o == '0));

   // R7: the unused code drives lines low and raises the flag
   a_r7_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_i && t2_i) |=> (bl_o == '0 && illegal_o && e1_o));

   // R3: the first edge in the pattern mode gives a zero pattern
   a_r3_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_i && !t2_i && !prev_ptest) |=> (bl_o == '0 && e1_o));
endmodule

bind ad_input_decoder ad_input_decoder_chk #(.N_IN(N_IN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .t1_i      (t1_i),
   .t2_i      (t2_i),
   .bl_o      (bl_o),
   .e1_o      (e1_o),
   .illegal_o (illegal_o)
);

// File: tb/ad_input_decoder_test.sv
module ad_input_decoder_test;
   localparam int N_IN = 4;
   localparam int N_BL = 2 * N_IN;
   localparam int PER  = N_BL + 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            t1_i = 1'b0;
   logic            t2_i = 1'b0;
   logic [N_IN-1:0] din_i = '0;
   logic [N_BL-1:0] bl_o;
   logic            e1_o;
   logic            illegal_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   ad_input_decoder #(.N_IN(N_IN)) uut (
      .clk (clk), .rst_n (rst_n), .t1_i (t1_i), .t2_i (t2_i),
      .din_i (din_i), .bl_o (bl_o), .e1_o (e1_o), .illegal_o (illegal_o)
   );

   function automatic logic [N_BL-1:0] dec_exp(input logic [N_IN-1:0] d);
      logic [N_BL-1:0] r;
      for (int k = 0; k < N_IN; k++) begin
         r[2*k]   = d[k];
         r[2*k+1] = ~d[k];
      end
      return r;
   endfunction

   function automatic logic [N_BL-1:0] seq_exp(input int p);
      if (p < 2) return '0;
      return N_BL'(1) << (p - 2);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      check("R10 lines after reset", 64'(bl_o), 64'(0));
      check("R10 flag after reset", 64'(illegal_o), 64'(0));
      check("R6 e1 after reset", 64'(e1_o), 64'(1));
   endtask

   task automatic t_decode;
      logic [N_IN-1:0] vals [4] = '{4'h0, 4'hF, 4'hA, 4'h6};
      t1_i = 0; t2_i = 0;
      foreach (vals[i]) begin
         din_i = vals[i];
         step();
         check("R1 decode", 64'(bl_o), 64'(dec_exp(vals[i])));
         check("R6 e1 low in decode", 64'(e1_o), 64'(0));
      end
   endtask

   task automatic t_sequence;
      t1_i = 1; t2_i = 0;
      for (int c = 0; c < 2 * PER; c++) begin
         din_i = N_IN'(c * 5 + 3);  // R9: changing inputs must not matter
         step();
         check((c % PER) < 2 ? "R3 lead zero" : (c >= PER ? "R5 repeat" : "R4 walk"),
               64'(bl_o), 64'(seq_exp(c % PER)));
         check("R6 e1 vs lines", 64'(e1_o), 64'((c % PER) < 2));
         check("R9 inputs ignored flag", 64'(illegal_o), 64'(0));
      end
   endtask

   task automatic t_force_mid;
      t1_i = 1; t2_i = 0;
      for (int c = 0; c < 5; c++) step();
      t1_i = 0; t2_i = 1;
      step();
      check("R2 forced low", 64'(bl_o), 64'(0));
      t1_i = 1; t2_i = 0;
      for (int c = 0; c < 3; c++) begin
         step();
         check("R2 restart after force", 64'(bl_o), 64'(seq_exp(c)));
      end
   endtask

   task automatic t_exit;
      t1_i = 1; t2_i = 0;
      for (int c = 0; c < 4; c++) step();
      t1_i = 0; din_i = 4'h9;
      step();
      check("R8 decode on exit", 64'(bl_o), 64'(dec_exp(4'h9)));
      t1_i = 1;
      for (int c = 0; c < 3; c++) begin
         step();
         check("R8 restart on re-entry", 64'(bl_o), 64'(seq_exp(c)));
      end
   endtask

   task automatic t_bad_code;
      t1_i = 1; t2_i = 1; din_i = 4'h5;
      step();
      check("R7 lines low", 64'(bl_o), 64'(0));
      check("R7 flag set", 64'(illegal_o), 64'(1));
      t1_i = 0; t2_i = 0;
      step();
      check("R7 flag clear", 64'(illegal_o), 64'(0));
      check("R1 decode after bad code", 64'(bl_o), 64'(dec_exp(4'h5)));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1;
      t_decode();
      t_sequence();
      t_force_mid();
      t_exit();
      t_bad_code();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule